// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Store With Delayed Match

This block is the tag side of a direct-mapped cache. It keeps one tag and one valid flag for every line index. A lookup presents an index and a request tag on the command inputs. Exactly two cycles later the block raises a registered hit pulse if the addressed entry is valid and its stored tag equals the request tag. The data array and bus ownership are handled elsewhere.

The same command port also carries four more commands. A tag write loads a tag and a valid flag, both sampled in the cycle the index is presented; it serves both block writes and miss fills. Invalidate drops the valid flag of one entry. Clear drops every valid flag at once. Probe reads back one entry's tag and valid flag on a separate pair of outputs, two cycles after it is issued. Only one command is accepted per cycle. Each lookup or probe sees the effect of every command issued in an earlier cycle, and of no command issued after it.

Top module: `tag_match_store`

## Requirements
- R1: After reset `match` and `probeDone` are low, and every entry is invalid, so a lookup of any index that has not been written since reset gives no hit.
- R2: A lookup (`cmd` = 1) presented in cycle n makes `match` high in cycle n+2 only, for that single cycle, when the hit condition of R3 holds. `match` is low in every cycle that is not two cycles after a lookup.
- R3: The hit condition is that the entry at `cmdIndex` has its valid flag set and its stored tag equals `cmdTag` in all bits. A differing tag or a cleared valid flag gives no hit.
- R4: A tag write (`cmd` = 2) stores `cmdTag` and the valid flag `cmdValid` into the entry at `cmdIndex`, all sampled in the same cycle. A write with `cmdValid` = 0 leaves that entry invalid.
- R5: The store is direct-mapped. A write, an invalidate or a probe touches only the entry at its own index, and other entries, including index 0 and the highest index, keep their contents.
- R6: Invalidate (`cmd` = 3) clears the valid flag of the entry at `cmdIndex` and keeps its stored tag.
- R7: Clear (`cmd` = 4) clears the valid flag of every entry in one cycle and keeps all stored tags.
- R8: A probe (`cmd` = 5) presented in cycle n raises `probeDone` in cycle n+2 for one cycle. In that cycle `probeTag` and `probeValid` show the entry's stored tag and valid flag. A probe changes no entry, and `probeTag` and `probeValid` hold their values until the next probe result.
- R9: A lookup reflects every command issued in earlier cycles and none issued in later cycles. Lookups issued in consecutive cycles each give their own result in consecutive cycles.
- R10: Command code 0 and the unused codes 6 and 7 change no entry and produce no `match` or `probeDone`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command: 0 idle, 1 lookup, 2 tag write, 3 invalidate, 4 clear, 5 probe |
| cmdIndex | input | IDX_W (10) | Line index of the command |
| cmdTag | input | TAG_W (17) | Request tag for a lookup, or the new tag for a write |
| cmdValid | input | 1 | Valid flag that a tag write stores |
| match | output | 1 | Registered hit pulse, two cycles after a lookup |
| probeDone | output | 1 | Pulse marking the probe result cycle |
| probeTag | output | TAG_W (17) | Stored tag from the last probe |
| probeValid | output | 1 | Stored valid flag from the last probe |

## Verification
The hardest case to reach from the ports is a change to an entry in the cycle just before or just after a lookup of that same entry. The lookup result must reflect the earlier command and ignore the later one, even though the compare stage overlaps the later write. The stimulus issues invalidates and writes back to back with lookups of the same index. It also runs lookups of hitting and missing entries in consecutive cycles, so that every pulse position is checked. Clear and invalidate are followed by probes, which show that the stored tags survive while the valid flags drop.

// File: rtl/tag_match_pkg.sv
package tag_match_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE   = 3'd0,
    CMD_LOOKUP = 3'd1,
    CMD_WRITE  = 3'd2,
    CMD_INVAL  = 3'd3,
    CMD_CLEAR  = 3'd4,
    CMD_PROBE  = 3'd5
  } cmdE;

  typedef struct packed {
    logic wrTag;
    logic clrOne;
    logic clrAll;
    logic capture;
    logic cmpNow;
    logic probeNow;
  } strobesT;

endpackage

// File: rtl/tag_match_ctrl.sv
module tag_match_ctrl
  import tag_match_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic [2:0] cmd,
  output strobesT strobes
);

  logic lookQ;
  logic probeQ;
  logic isLook;
  logic isProbe;

  always_comb begin
    isLook  = 1'b0;
    isProbe = 1'b0;
    strobes = '0;
    case (cmd)
      CMD_LOOKUP: isLook  = 1'b1;
      CMD_PROBE:  isProbe = 1'b1;
      CMD_WRITE:  strobes.wrTag  = 1'b1;
      CMD_INVAL:  strobes.clrOne = 1'b1;
      CMD_CLEAR:  strobes.clrAll = 1'b1;
      default:    ;
    endcase
    strobes.capture  = isLook | isProbe;
    strobes.cmpNow   = lookQ;
    strobes.probeNow = probeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lookQ  <= 1'b0;
      probeQ <= 1'b0;
    end else begin
      lookQ  <= isLook;
      probeQ <= isProbe;
    end
  end

endmodule

// File: rtl/tag_match_dp.sv
module tag_match_dp
  import tag_match_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TAG_W = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobesT          strobes,
  input  logic [IDX_W-1:0] cmdIndex,
  input  logic [TAG_W-1:0] cmdTag,
  input  logic             cmdValid,
  output logic             match,
  output logic             probeDone,
  output logic [TAG_W-1:0] probeTag,
  output logic             probeValid
);

  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tagMem [DEPTH];
  logic [DEPTH-1:0] validBits;
  logic [IDX_W-1:0] idxQ;
  logic [TAG_W-1:0] tagQ;
  logic [TAG_W-1:0] rdTag;
  logic             rdValid;

  always_ff @(posedge clk) begin
    if (strobes.wrTag) tagMem[cmdIndex] <= cmdTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
    end else if (strobes.clrAll) begin
      validBits <= '0;
    end else if (strobes.wrTag) begin
      validBits[cmdIndex] <= cmdValid;
    end else if (strobes.clrOne) begin
      validBits[cmdIndex] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      tagQ <= '0;
    end else if (strobes.capture) begin
      idxQ <= cmdIndex;
      tagQ <= cmdTag;
    end
  end

  always_comb begin
    rdTag   = tagMem[idxQ];
    rdValid = validBits[idxQ];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      match      <= 1'b0;
      probeDone  <= 1'b0;
      probeTag   <= '0;
      probeValid <= 1'b0;
    end else begin
      match     <= strobes.cmpNow && rdValid && (rdTag == tagQ);
      probeDone <= strobes.probeNow;
      if (strobes.probeNow) begin
        probeTag   <= rdTag;
        probeValid <= rdValid;
      end
    end
  end

endmodule

// File: rtl/tag_match_store.sv
module tag_match_store
  import tag_match_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TAG_W = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cmd,
  input  logic [IDX_W-1:0] cmdIndex,
  input  logic [TAG_W-1:0] cmdTag,
  input  logic             cmdValid,
  output logic             match,
  output logic             probeDone,
  output logic [TAG_W-1:0] probeTag,
  output logic             probeValid
);

  strobesT strobes;

  tag_match_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .strobes (strobes)
  );

  tag_match_dp #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cmdIndex   (cmdIndex),
    .cmdTag     (cmdTag),
    .cmdValid   (cmdValid),
    .match      (match),
    .probeDone  (probeDone),
    .probeTag   (probeTag),
    .probeValid (probeValid)
  );

endmodule

// File: rtl/tag_match_store_chk.sv
module tag_match_store_chk
  import tag_match_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TAG_W = 17
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       cmd,
  input logic [IDX_W-1:0] cmdIndex,
  input logic [TAG_W-1:0] cmdTag,
  input logic             cmdValid,
  input logic             match,
  input logic             probeDone,
  input logic [TAG_W-1:0] probeTag,
  input logic             probeValid
);

  logic [1:0] cyc;

  always_ff @(posedge clk) begin
    if (!rstN) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R1: no result pulse in the first two cycles after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cyc < 2'd2) |-> (!match && !probeDone));

  // R2: a hit only ever follows a lookup by two cycles
  p_match_follows_lookup_r2: assert property (@(posedge clk) disable iff (!rstN)
    match |-> (cyc >= 2'd2 && $past(cmd, 2) == CMD_LOOKUP));

  // R4: a valid write followed by a lookup of the same index and tag hits
  p_write_then_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd1 && cmd == CMD_LOOKUP && $past(cmd) == CMD_WRITE && $past(cmdValid)
     && $past(cmdIndex) == cmdIndex && $past(cmdTag) == cmdTag) |-> ##2 match);

  // R6: invalidate followed by a lookup of the same index gives no hit
  p_inval_then_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd1 && cmd == CMD_LOOKUP && $past(cmd) == CMD_INVAL
     && $past(cmdIndex) == cmdIndex) |-> ##2 !match);

  // R7: clear followed by any lookup gives no hit
  p_clear_then_miss_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd1 && cmd == CMD_LOOKUP && $past(cmd) == CMD_CLEAR) |-> ##2 !match);

  // R8: probe result appears exactly two cycles after a probe
  p_probe_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd2) |-> (probeDone == ($past(cmd, 2) == CMD_PROBE)));

  // R8: probe outputs hold between probe results
  p_probe_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd1 && !probeDone) |-> ($stable(probeTag) && $stable(probeValid)));

endmodule

bind tag_match_store tag_match_store_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/tag_match_store_bench.sv
`timescale 1ns/1ps
module tag_match_store_bench;

  localparam int IDX_W = 10;
  localparam int TAG_W = 17;
  localparam logic [IDX_W-1:0] TOP_IDX = '1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [2:0]       cmd = 3'd0;
  logic [IDX_W-1:0] cmdIndex = '0;
  logic [TAG_W-1:0] cmdTag = '0;
  logic             cmdValid = 1'b0;
  logic             match;
  logic             probeDone;
  logic [TAG_W-1:0] probeTag;
  logic             probeValid;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tag_match_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag_match_store (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [IDX_W-1:0] i,
                       input logic [TAG_W-1:0] t, input logic v);
    cmd = c; cmdIndex = i; cmdTag = t; cmdValid = v;
    @(negedge clk);
    cmd = 3'd0; cmdIndex = '0; cmdTag = '0; cmdValid = 1'b0;
  endtask

  task automatic wr(input logic [IDX_W-1:0] i, input logic [TAG_W-1:0] t, input logic v);
    drive(3'd2, i, t, v);
  endtask

  // lookup issued now; match checked low next cycle, then expected value
  task automatic look(input string req, input logic [IDX_W-1:0] i,
                      input logic [TAG_W-1:0] t, input logic exp);
    drive(3'd1, i, t, 1'b0);
    chk({req, " match early"}, match, 0);
    @(negedge clk);
    chk({req, " match"}, match, exp);
    @(negedge clk);
    chk({req, " match one cycle"}, match, 0);
  endtask

  task automatic probe(input string req, input logic [IDX_W-1:0] i,
                       input logic [TAG_W-1:0] expTag, input logic expV);
    drive(3'd5, i, '0, 1'b0);
    chk({req, " probeDone early"}, probeDone, 0);
    @(negedge clk);
    chk({req, " probeDone"}, probeDone, 1);
    chk({req, " probeTag"}, probeTag, expTag);
    chk({req, " probeValid"}, probeValid, expV);
    @(negedge clk);
    chk({req, " probeDone one cycle"}, probeDone, 0);
    chk({req, " probeTag hold"}, probeTag, expTag);
  endtask

  task automatic test_reset;
    chk("R1 match at reset", match, 0);
    chk("R1 probeDone at reset", probeDone, 0);
    look("R1 unwritten idx0", '0, '0, 0);
    look("R1 unwritten top", TOP_IDX, 17'h1ABCD, 0);
  endtask

  task automatic test_write_lookup;
    wr(10'h005, 17'h1ABCD, 1'b1);
    look("R2 hit", 10'h005, 17'h1ABCD, 1);
    look("R3 tag differs lsb", 10'h005, 17'h1ABCC, 0);
    look("R3 tag differs msb", 10'h005, 17'h0ABCD, 0);
    wr(10'h006, 17'h00F0F, 1'b0);
    look("R4 written invalid", 10'h006, 17'h00F0F, 0);
    wr(10'h006, 17'h00F0F, 1'b1);
    look("R4 rewritten valid", 10'h006, 17'h00F0F, 1);
    wr(10'h006, 17'h13579, 1'b1);
    look("R4 overwrite new tag", 10'h006, 17'h13579, 1);
    look("R4 overwrite old tag", 10'h006, 17'h00F0F, 0);
  endtask

  task automatic test_direct_map;
    wr('0, 17'h00001, 1'b1);
    wr(TOP_IDX, 17'h1FFFF, 1'b1);
    look("R5 idx0", '0, 17'h00001, 1);
    look("R5 top idx", TOP_IDX, 17'h1FFFF, 1);
    look("R5 neighbour of 5", 10'h004, 17'h1ABCD, 0);
    look("R5 alias index", 10'h205, 17'h1ABCD, 0);
    look("R5 idx5 kept", 10'h005, 17'h1ABCD, 1);
  endtask

  task automatic test_inval_probe;
    probe("R8 probe idx5", 10'h005, 17'h1ABCD, 1'b1);
    look("R8 probe changed nothing", 10'h005, 17'h1ABCD, 1);
    drive(3'd3, 10'h005, '0, 1'b0);
    look("R6 invalidated", 10'h005, 17'h1ABCD, 0);
    probe("R6 tag kept", 10'h005, 17'h1ABCD, 1'b0);
    look("R6 other entry kept", 10'h006, 17'h13579, 1);
  endtask

  task automatic test_ignored_codes;
    drive(3'd6, 10'h006, 17'h00000, 1'b0);
    chk("R10 code6 no probeDone", probeDone, 0);
    drive(3'd7, 10'h006, 17'h00000, 1'b0);
    chk("R10 code6 no match", match, 0);
    chk("R10 code6 no probeDone 2", probeDone, 0);
    drive(3'd0, 10'h006, 17'h00000, 1'b0);
    chk("R10 code7 no match", match, 0);
    @(negedge clk);
    chk("R10 idle no match", match, 0);
    look("R10 entry unchanged", 10'h006, 17'h13579, 1);
  endtask

  task automatic test_ordering;
    wr(10'h010, 17'h0AAAA, 1'b1);
    // lookup then invalidate next cycle: lookup still hits
    drive(3'd1, 10'h010, 17'h0AAAA, 1'b0);
    drive(3'd3, 10'h010, '0, 1'b0);
    chk("R9 later inval ignored", match, 1);
    // invalidate then lookup next cycle: miss
    wr(10'h010, 17'h0AAAA, 1'b1);
    drive(3'd3, 10'h010, '0, 1'b0);
    look("R9 earlier inval seen", 10'h010, 17'h0AAAA, 0);
    // write immediately followed by lookup
    wr(10'h011, 17'h05555, 1'b1);
    look("R9 earlier write seen", 10'h011, 17'h05555, 1);
    // lookup of stale entry followed by write that would hit
    drive(3'd1, 10'h012, 17'h07777, 1'b0);
    wr(10'h012, 17'h07777, 1'b1);
    chk("R9 later write ignored", match, 0);
    // back-to-back lookups hit, miss, hit
    drive(3'd1, 10'h011, 17'h05555, 1'b0);
    drive(3'd1, 10'h011, 17'h05554, 1'b0);
    chk("R9 b2b first", match, 1);
    drive(3'd1, 10'h012, 17'h07777, 1'b0);
    chk("R9 b2b second", match, 0);
    @(negedge clk);
    chk("R9 b2b third", match, 1);
    @(negedge clk);
    chk("R9 b2b end", match, 0);
  endtask

  task automatic test_clear;
    drive(3'd4, '0, '0, 1'b0);
    look("R7 idx0 cleared", '0, 17'h00001, 0);
    look("R7 top cleared", TOP_IDX, 17'h1FFFF, 0);
    look("R7 idx11 cleared", 10'h011, 17'h05555, 0);
    probe("R7 tag kept top", TOP_IDX, 17'h1FFFF, 1'b0);
    probe("R7 tag kept 11", 10'h011, 17'h05555, 1'b0);
    wr(10'h011, 17'h05555, 1'b1);
    look("R7 refill after clear", 10'h011, 17'h05555, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_write_lookup();
    test_direct_map();
    test_inval_probe();
    test_ignored_codes();
    test_ordering();
    test_clear();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule